// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block holds the tag and state side of a set-associative cache. For each set it keeps a number of ways, and each way holds four things: an occupancy bit, the full line address, a two-bit access permission and a lock owner. It also keeps a tree pseudo-LRU word per set. A controller sends at most one request per cycle on a single request port. The opcode selects the operation: an access check for a given request type, a presence test, a lookup that ignores permission, an availability query, allocate, deallocate, a victim probe, a recency touch, a permission write, or one of the three lock operations.

Lookups are combinational. A response appears in the same cycle as its request. Any change to the directory state is written on the next rising clock edge, so the following request already sees it. The block holds no data array and runs no coherence protocol; permissions are written by the controller through the permission-write opcode.

The request dispatch is an enumerated opcode decoded with a unique case. One process drives the responses and one process updates the registered directory state. The opcodes are NOP(0), ACCESS(1), PRESENT(2), AVAIL(3), ALLOC(4), DEALLOC(5), PROBE(6), TOUCH(7), LOCK_SET(8), LOCK_CLR(9), LOCK_TEST(10), LOOKUP_RAW(11) and PERM_WR(12).

Top module: `ctag_dir`

## Requirements
- R1: The set is selected by address bits [IDX_LO +: log2(SETS)], and SETS must be at least 2. Requests to one set never read or change the lines of another set.
- R2: Permission codes are 0 not-present, 1 invalid, 2 read-only and 3 read-write. PRESENT sets rsp_flag when some occupied way stores the request address with a permission other than 0, and rsp_way gives the lowest such way. LOOKUP_RAW does the same but matches on occupancy and address alone.
- R3: Request type codes are 0 load, 1 instruction fetch and 2 store. ACCESS sets rsp_flag when the present line is read-write, or when it is read-only and the type is load or instruction fetch. In every other case rsp_flag is 0.
- R4: An ACCESS that finds the line present touches the replacement state for that way, even when the access is refused.
- R5: AVAIL sets rsp_flag when some way of the set is empty, has permission 0, or is occupied with the request address.
- R6: ALLOC writes the lowest way that is empty or has permission 0. It stores the address, sets the permission to 1 and the lock owner to all ones, touches the way, and returns it on rsp_way with rsp_flag set. When no such way exists, rsp_err is set and nothing changes.
- R7: DEALLOC of a present address empties its way. DEALLOC of an absent address changes nothing.
- R8: PROBE returns on rsp_way the way chosen by the per-set pseudo-LRU tree, and on rsp_addr the address stored in that way. rsp_flag is set when the probe is legal, which is when AVAIL would be false.
- R9: TOUCH updates the replacement state only when the address is present. Otherwise it has no effect.
- R10: LOCK_SET writes req_ctx as the owner and LOCK_CLR writes all ones (unlocked). LOCK_TEST sets rsp_flag only when the stored owner equals req_ctx. All three set rsp_err and change nothing when the address is not present.
- R11: PERM_WR writes req_perm to the lowest way that matches the address on the raw lookup, and sets rsp_flag when such a way exists.
- R12: The pseudo-LRU tree has WAYS-1 bits per set and is cleared by reset; reset also empties every way. A touch points each node on the path away from the touched way, and the victim walk follows the node bits, with 0 meaning the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 4 | Request opcode |
| req_addr | input | ADDR_W | Line-aligned request address |
| req_type | input | 2 | Access type for ACCESS |
| req_ctx | input | CTX_W | Context ID for lock operations |
| req_perm | input | 2 | Permission value for PERM_WR |
| rsp_flag | output | 1 | Hit, grant, availability, legality or lock-match result |
| rsp_way | output | log2(WAYS) | Matched, allocated or victim way |
| rsp_addr | output | ADDR_W | Victim line address on PROBE, else zero |
| rsp_err | output | 1 | Allocation with no free way, or lock operation on an absent address |

## Verification
Every response is combinational, so it is due in the cycle its request is applied. The bench drives each request at a falling edge and compares the outputs a few nanoseconds later, before the next rising edge. State changes are due one rising edge later. The bench updates its reference model only after the comparison, so the next request, driven at the following falling edge, already checks the new state. Victim and touch effects are therefore observed through later PROBE requests, and lock and permission writes through later LOCK_TEST, ACCESS and PRESENT requests.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_ACCESS     = 4'd1,
        OP_PRESENT    = 4'd2,
        OP_AVAIL      = 4'd3,
        OP_ALLOC      = 4'd4,
        OP_DEALLOC    = 4'd5,
        OP_PROBE      = 4'd6,
        OP_TOUCH      = 4'd7,
        OP_LOCK_SET   = 4'd8,
        OP_LOCK_CLR   = 4'd9,
        OP_LOCK_TEST  = 4'd10,
        OP_LOOKUP_RAW = 4'd11,
        OP_PERM_WR    = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_INV  = 2'd1,
        PERM_RO   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        RT_LOAD  = 2'd0,
        RT_FETCH = 2'd1,
        RT_STORE = 2'd2
    } rtype_e;

endpackage

// File: rtl/ctag_match.sv
module ctag_match #(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 12,
    localparam int WB    = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][ADDR_W-1:0] tags_i,
    input  logic [WAYS-1:0][1:0]        perms_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic                        any_raw_o,
    output logic                        any_pres_o,
    output logic                        any_free_o,
    output logic                        avail_o,
    output logic [WB-1:0]               raw_way_o,
    output logic [WB-1:0]               pres_way_o,
    output logic [WB-1:0]               free_way_o
);
    logic [WAYS-1:0] raw_v, pres_v, free_v;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign raw_v[w]  = valid_i[w] && (tags_i[w] == addr_i);
        assign pres_v[w] = raw_v[w] && (perms_i[w] != ctag_pkg::PERM_NONE);
        assign free_v[w] = !valid_i[w] || (perms_i[w] == ctag_pkg::PERM_NONE);
    end

    function automatic logic [WB-1:0] lowest(input logic [WAYS-1:0] v);
        logic [WB-1:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (v[i]) r = WB'(i);
        end
        return r;
    endfunction

    assign any_raw_o  = |raw_v;
    assign any_pres_o = |pres_v;
    assign any_free_o = |free_v;
    assign avail_o    = |(raw_v | free_v);
    assign raw_way_o  = lowest(raw_v);
    assign pres_way_o = lowest(pres_v);
    assign free_way_o = lowest(free_v);
endmodule

// File: rtl/ctag_plru.sv
module ctag_plru #(
    parameter int WAYS  = 4,
    localparam int WB   = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic [NODES-1:0] bits_i,
    input  logic [WB-1:0]    touch_way_i,
    output logic [NODES-1:0] bits_o,
    output logic [WB-1:0]    victim_o
);
    always_comb begin
        int n;
        bits_o = bits_i;
        n = 0;
        for (int l = 0; l < WB; l++) begin
            bits_o[n] = ~touch_way_i[WB-1-l];
            n = 2 * n + 1 + int'(touch_way_i[WB-1-l]);
        end
    end

    always_comb begin
        int m;
        victim_o = '0;
        m = 0;
        for (int l = 0; l < WB; l++) begin
            victim_o[WB-1-l] = bits_i[m];
            m = 2 * m + 1 + int'(bits_i[m]);
        end
    end
endmodule

// File: rtl/ctag_dir.sv
module ctag_dir #(
    parameter int ADDR_W = 12,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int IDX_LO = 4,
    parameter int CTX_W  = 4,
    localparam int SB    = $clog2(SETS),
    localparam int WB    = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_type,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [1:0]        req_perm,
    output logic              rsp_flag,
    output logic [WB-1:0]     rsp_way,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_err
);
    import ctag_pkg::*;

    localparam logic [CTX_W-1:0] UNLOCKED = '1;

    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0] tag_q;
    logic [SETS-1:0][WAYS-1:0][1:0]        perm_q;
    logic [SETS-1:0][WAYS-1:0][CTX_W-1:0]  lock_q;
    logic [SETS-1:0][NODES-1:0]            plru_q;

    op_e           op;
    logic [SB-1:0] set_idx;
    logic          any_raw, any_pres, any_free, avail;
    logic [WB-1:0] raw_way, pres_way, free_way, victim, touch_way;
    logic [NODES-1:0] plru_next;
    logic          touch_en, grant;

    assign op      = op_e'(req_op);
    assign set_idx = req_addr[IDX_LO +: SB];

    ctag_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
        .valid_i    (valid_q[set_idx]),
        .tags_i     (tag_q[set_idx]),
        .perms_i    (perm_q[set_idx]),
        .addr_i     (req_addr),
        .any_raw_o  (any_raw),
        .any_pres_o (any_pres),
        .any_free_o (any_free),
        .avail_o    (avail),
        .raw_way_o  (raw_way),
        .pres_way_o (pres_way),
        .free_way_o (free_way)
    );

    assign touch_way = (op == OP_ALLOC) ? free_way : pres_way;

    ctag_plru #(.WAYS(WAYS)) u_plru (
        .bits_i      (plru_q[set_idx]),
        .touch_way_i (touch_way),
        .bits_o      (plru_next),
        .victim_o    (victim)
    );

    always_comb begin
        unique case (perm_e'(perm_q[set_idx][pres_way]))
            PERM_RW: grant = any_pres;
            PERM_RO: grant = any_pres && (req_type != RT_STORE);
            default: grant = 1'b0;
        endcase
    end

    // output process
    always_comb begin
        rsp_flag = 1'b0;
        rsp_way  = '0;
        rsp_addr = '0;
        rsp_err  = 1'b0;
        touch_en = 1'b0;
        unique case (op)
            OP_ACCESS: begin
                rsp_flag = grant;
                rsp_way  = pres_way;
                touch_en = any_pres;
            end
            OP_PRESENT: begin
                rsp_flag = any_pres;
                rsp_way  = pres_way;
            end
            OP_AVAIL: rsp_flag = avail;
            OP_ALLOC: begin
                rsp_flag = any_free;
                rsp_way  = free_way;
                rsp_err  = !any_free;
                touch_en = any_free;
            end
            OP_DEALLOC: begin
                rsp_flag = any_pres;
                rsp_way  = pres_way;
            end
            OP_PROBE: begin
                rsp_flag = !avail;
                rsp_way  = victim;
                rsp_addr = tag_q[set_idx][victim];
            end
            OP_TOUCH: begin
                rsp_flag = any_pres;
                rsp_way  = pres_way;
                touch_en = any_pres;
            end
            OP_LOCK_SET, OP_LOCK_CLR: begin
                rsp_flag = any_pres;
                rsp_way  = pres_way;
                rsp_err  = !any_pres;
            end
            OP_LOCK_TEST: begin
                rsp_flag = any_pres && (lock_q[set_idx][pres_way] == req_ctx);
                rsp_way  = pres_way;
                rsp_err  = !any_pres;
            end
            OP_LOOKUP_RAW, OP_PERM_WR: begin
                rsp_flag = any_raw;
                rsp_way  = raw_way;
            end
            default: ;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            perm_q  <= '0;
            lock_q  <= '1;
            plru_q  <= '0;
        end else begin
            if (touch_en) plru_q[set_idx] <= plru_next;
            unique case (op)
                OP_ALLOC: if (any_free) begin
                    valid_q[set_idx][free_way] <= 1'b1;
                    tag_q[set_idx][free_way]   <= req_addr;
                    perm_q[set_idx][free_way]  <= PERM_INV;
                    lock_q[set_idx][free_way]  <= UNLOCKED;
                end
                OP_DEALLOC: if (any_pres) valid_q[set_idx][pres_way] <= 1'b0;
                OP_LOCK_SET: if (any_pres) lock_q[set_idx][pres_way] <= req_ctx;
                OP_LOCK_CLR: if (any_pres) lock_q[set_idx][pres_way] <= UNLOCKED;
                OP_PERM_WR: if (any_raw) perm_q[set_idx][raw_way] <= req_perm;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctag_dir_chk.sv
module ctag_dir_chk #(
    parameter int ADDR_W = 12,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int IDX_LO = 4,
    parameter int CTX_W  = 4,
    localparam int SB    = $clog2(SETS),
    localparam int WB    = $clog2(WAYS)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [3:0]                       req_op,
    input logic [ADDR_W-1:0]                req_addr,
    input logic [1:0]                       req_type,
    input logic [CTX_W-1:0]                 req_ctx,
    input logic                             rsp_flag,
    input logic [WB-1:0]                    rsp_way,
    input logic                             rsp_err,
    input logic [SETS-1:0][WAYS-1:0]        valid_q,
    input logic [SETS-1:0][WAYS-1:0][1:0]   perm_q,
    input logic [SETS-1:0][WAYS-1:0][CTX_W-1:0] lock_q
);
    logic [SB-1:0] s;
    assign s = req_addr[IDX_LO +: SB];

    assert_store_needs_rw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 4'd1 && rsp_flag && req_type == 2'd2) |-> perm_q[s][rsp_way] == 2'd3);

    assert_grant_needs_readable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 4'd1 && rsp_flag) |-> perm_q[s][rsp_way][1]);

    assert_alloc_fills_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 4'd4 && !rsp_err) |=>
        (valid_q[$past(s)][$past(rsp_way)] && perm_q[$past(s)][$past(rsp_way)] == 2'd1
         && lock_q[$past(s)][$past(rsp_way)] == '1));

    assert_alloc_err_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 4'd4 && rsp_err) |-> &valid_q[s]);

    assert_dealloc_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 4'd5 && rsp_flag) |=> !valid_q[$past(s)][$past(rsp_way)]);

    assert_probe_victim_occupied_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 4'd6 && rsp_flag) |-> valid_q[s][rsp_way]);

    assert_lock_set_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 4'd8 && !rsp_err) |=> lock_q[$past(s)][$past(rsp_way)] == $past(req_ctx));
endmodule

bind ctag_dir ctag_dir_chk #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .IDX_LO(IDX_LO), .CTX_W(CTX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_op   (req_op),
    .req_addr (req_addr),
    .req_type (req_type),
    .req_ctx  (req_ctx),
    .rsp_flag (rsp_flag),
    .rsp_way  (rsp_way),
    .rsp_err  (rsp_err),
    .valid_q  (valid_q),
    .perm_q   (perm_q),
    .lock_q   (lock_q)
);

// File: tb/test_ctag_dir.sv
module test_ctag_dir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_op = '0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_type = '0;
    logic [3:0]  req_ctx = '0;
    logic [1:0]  req_perm = '0;
    logic        rsp_flag;
    logic [1:0]  rsp_way;
    logic [11:0] rsp_addr;
    logic        rsp_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ctag_dir i_ctag_dir (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
        .req_type(req_type), .req_ctx(req_ctx), .req_perm(req_perm),
        .rsp_flag(rsp_flag), .rsp_way(rsp_way), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
    );

    // reference model for 4 sets x 4 ways
    bit         mv[4][4];
    logic [11:0] mt[4][4];
    logic [1:0] mp[4][4];
    logic [3:0] ml[4][4];
    logic [2:0] mb[4];

    function automatic logic [11:0] mk(input int s, input int tag);
        return {6'(tag), 2'(s), 4'h0};
    endfunction

    function automatic logic [1:0] mvict(input int s);
        if (mb[s][0] == 1'b0) return {1'b0, mb[s][1]};
        else                  return {1'b1, mb[s][2]};
    endfunction

    task automatic mtouch(input int s, input logic [1:0] w);
        mb[s][0] = ~w[1];
        if (w[1] == 1'b0) mb[s][1] = ~w[0];
        else              mb[s][2] = ~w[0];
    endtask

    task automatic apply(input logic [3:0] op, input logic [11:0] a, input logic [1:0] ty,
                         input logic [3:0] cx, input logic [1:0] pm, input string rq);
        int s;
        bit anyr, anyp, anyf, av;
        logic [1:0] rw, pw, fw;
        logic ef, ee;
        logic [1:0] ew;
        logic [11:0] ea;
        s = int'(a[5:4]);
        anyr = 0; anyp = 0; anyf = 0; rw = 0; pw = 0; fw = 0;
        for (int w = 3; w >= 0; w--) begin
            if (mv[s][w] && mt[s][w] == a) begin
                anyr = 1; rw = 2'(w);
                if (mp[s][w] != 2'd0) begin anyp = 1; pw = 2'(w); end
            end
        end
        for (int w = 3; w >= 0; w--)
            if (!mv[s][w] || mp[s][w] == 2'd0) begin anyf = 1; fw = 2'(w); end
        av = anyr || anyf;
        ef = 0; ew = 0; ea = 0; ee = 0;
        case (op)
            4'd1: begin
                ew = pw;
                ef = anyp && (mp[s][pw] == 2'd3 || (mp[s][pw] == 2'd2 && ty != 2'd2));
            end
            4'd2, 4'd5, 4'd7: begin ef = anyp; ew = pw; end
            4'd3: ef = av;
            4'd4: begin ef = anyf; ew = fw; ee = !anyf; end
            4'd6: begin ew = mvict(s); ef = !av; ea = mt[s][ew]; end
            4'd8, 4'd9: begin ef = anyp; ew = pw; ee = !anyp; end
            4'd10: begin ef = anyp && ml[s][pw] == cx; ew = pw; ee = !anyp; end
            4'd11, 4'd12: begin ef = anyr; ew = rw; end
            default: ;
        endcase
        @(negedge clk);
        req_op = op; req_addr = a; req_type = ty; req_ctx = cx; req_perm = pm;
        #3;
        checks++;
        if (rsp_flag !== ef || rsp_way !== ew || rsp_addr !== ea || rsp_err !== ee) begin
            fails++;
            $display("FAIL %s op=%0d addr=%h: flag/way/addr/err actual %b/%0d/%h/%b expected %b/%0d/%h/%b",
                     rq, op, a, rsp_flag, rsp_way, rsp_addr, rsp_err, ef, ew, ea, ee);
        end
        case (op)
            4'd1, 4'd7: if (anyp) mtouch(s, pw);
            4'd4: if (anyf) begin
                mv[s][fw] = 1; mt[s][fw] = a; mp[s][fw] = 2'd1; ml[s][fw] = 4'hF;
                mtouch(s, fw);
            end
            4'd5: if (anyp) mv[s][pw] = 0;
            4'd8: if (anyp) ml[s][pw] = cx;
            4'd9: if (anyp) ml[s][pw] = 4'hF;
            4'd12: if (anyr) mp[s][rw] = pm;
            default: ;
        endcase
    endtask

    initial begin
        for (int s = 0; s < 4; s++) begin
            mb[s] = 0;
            for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mt[s][w] = 0; mp[s][w] = 0; ml[s][w] = 4'hF; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset leaves every set empty and available
        for (int s = 0; s < 4; s++) begin
            apply(4'd2, mk(s, 1), 0, 0, 0, "R12");
            apply(4'd3, mk(s, 1), 0, 0, 0, "R12");
            apply(4'd6, mk(s, 1), 0, 0, 0, "R12");
        end
        // R6/R1: fill each set; lowest free way; full set errors
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) apply(4'd4, mk(s, s * 8 + t + 1), 0, 0, 0, "R6");
            apply(4'd4, mk(s, 60), 0, 0, 0, "R6");
            apply(4'd3, mk(s, 60), 0, 0, 0, "R5");
            apply(4'd3, mk(s, s * 8 + 2), 0, 0, 0, "R5");
            apply(4'd6, mk(s, 60), 0, 0, 0, "R8");
        end
        // R1: an address of set 1 is not seen in set 2
        apply(4'd2, mk(2, 9), 0, 0, 0, "R1");
        apply(4'd2, mk(1, 9), 0, 0, 0, "R1");
        // R11/R2/R3/R4: permissions rotated per set, every type on every way
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) apply(4'd12, mk(s, s * 8 + w + 1), 0, 0, 2'((w + s) % 4), "R11");
            for (int w = 0; w < 4; w++) begin
                apply(4'd2, mk(s, s * 8 + w + 1), 0, 0, 0, "R2");
                apply(4'd11, mk(s, s * 8 + w + 1), 0, 0, 0, "R2");
                for (int ty = 0; ty < 3; ty++) begin
                    apply(4'd1, mk(s, s * 8 + w + 1), 2'(ty), 0, 0, "R3");
                    apply(4'd6, mk(s, 61), 0, 0, 0, "R4");
                end
            end
            apply(4'd3, mk(s, 61), 0, 0, 0, "R5");
        end
        // R9: touch present and absent addresses, then probe
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) apply(4'd12, mk(s, s * 8 + w + 1), 0, 0, 2'd2, "R11");
            for (int w = 3; w >= 0; w--) begin
                apply(4'd7, mk(s, s * 8 + w + 1), 0, 0, 0, "R9");
                apply(4'd6, mk(s, 62), 0, 0, 0, "R8");
                apply(4'd7, mk(s, 62), 0, 0, 0, "R9");
                apply(4'd6, mk(s, 62), 0, 0, 0, "R9");
            end
        end
        // R10: lock set, test, clear, absent
        for (int s = 0; s < 4; s++) begin
            apply(4'd10, mk(s, s * 8 + 2), 0, 4'd3, 0, "R10");
            apply(4'd10, mk(s, s * 8 + 2), 0, 4'hF, 0, "R10");
            apply(4'd8,  mk(s, s * 8 + 2), 0, 4'(s + 3), 0, "R10");
            apply(4'd10, mk(s, s * 8 + 2), 0, 4'(s + 3), 0, "R10");
            apply(4'd10, mk(s, s * 8 + 2), 0, 4'd5, 0, "R10");
            apply(4'd10, mk(s, s * 8 + 3), 0, 4'(s + 3), 0, "R10");
            apply(4'd9,  mk(s, s * 8 + 2), 0, 0, 0, "R10");
            apply(4'd10, mk(s, s * 8 + 2), 0, 4'(s + 3), 0, "R10");
            apply(4'd8,  mk(s, 63), 0, 4'd1, 0, "R10");
            apply(4'd10, mk(s, 63), 0, 4'd1, 0, "R10");
        end
        // R7/R6: deallocate, absent deallocate, refill lowest hole, not-present reuse
        for (int s = 0; s < 4; s++) begin
            apply(4'd5, mk(s, s * 8 + 3), 0, 0, 0, "R7");
            apply(4'd2, mk(s, s * 8 + 3), 0, 0, 0, "R7");
            apply(4'd5, mk(s, 59), 0, 0, 0, "R7");
            apply(4'd12, mk(s, s * 8 + 4), 0, 0, 2'd0, "R11");
            apply(4'd3, mk(s, 58), 0, 0, 0, "R5");
            apply(4'd4, mk(s, 58), 0, 0, 0, "R6");
            apply(4'd4, mk(s, 57), 0, 0, 0, "R6");
            apply(4'd1, mk(s, 57), 2'd0, 0, 0, "R3");
            apply(4'd10, mk(s, 57), 0, 4'hF, 0, "R6");
            apply(4'd4, mk(s, 56), 0, 0, 0, "R6");
            apply(4'd6, mk(s, 56), 0, 0, 0, "R8");
        end
        apply(4'd0, 12'h0, 0, 0, 0, "R12");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL R12 watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule